// File: doc/BRIEF.md
# Burst Read-Increment-Writeback Manager

This block is a bus manager that performs one read-modify-write job on a block of memory. When the command port receives a start pulse with a base address, the block reads one incrementing burst of `BEATS` beats from that address. It stores each returned word, plus one, in a local slot store. It opens the write burst to the same address only after the read burst has fully finished. It then streams the stored words out, collects the write response, and pulses a completion strobe with an error flag.

The whole job is held locally before any write request appears. As a result, the write data never depends on a read that is still in flight, and every ready the block drives is held high for as long as it waits on its own channel. The block uses a single transaction ID, runs one job at a time, and uses full-width incrementing bursts only.

Top module: `burst_rmw_mgr`

## Requirements
- R1: After reset all five valid/ready outputs the block drives are low, and `jobDone` and `jobErr` are low.
- R2: A `jobStart` seen while idle produces exactly one read request with address = `jobAddr`, length field = BEATS-1 (15), size code = log2(DATA_W/8) (2 for 32 bits), burst code 2'b01 (incrementing) and ID = `JOB_ID`.
- R3: From the read-address handshake until the beat carrying `rLast` is taken, `rReady` stays high without a gap.
- R4: Write-back beat k carries read beat k plus one, modulo 2^DATA_W (so all-ones becomes zero). Beats are stored at successive slots in arrival order.
- R5: `awValid` rises only after the read beat with `rLast` has been accepted. The write request uses the same address, length, size, burst code and ID as the read request.
- R6: The write burst has exactly BEATS beats with `wStrb` all ones. `wLast` is high on the final beat and on no other.
- R7: `arValid`, `awValid` and `wValid`, once high, stay high with their address or data unchanged until the matching ready is seen.
- R8: `bReady` is high from the last write beat until the response arrives. `jobDone` is high for exactly one cycle, in the cycle after the response handshake.
- R9: A non-zero `rResp` or `bResp`, or an `rId`/`bId` differing from `JOB_ID`, makes `jobErr` high when `jobDone` pulses. The job still completes every channel. A new start clears `jobErr`.
- R10: If `rLast` arrives before beat BEATS or after it, `jobErr` is raised. Only the first BEATS beats are stored, and slots not written keep their previous contents. The write burst is still exactly BEATS beats.
- R11: `jobStart` has no effect while a job is in progress: the running job keeps its address, and no new request follows its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| jobStart | input | 1 | Start pulse, taken only when idle |
| jobAddr | input | ADDR_W | Base address of the job |
| jobDone | output | 1 | One-cycle completion pulse |
| jobErr | output | 1 | Sticky error of the current or last job |
| arValid | output | 1 | Read request valid |
| arReady | input | 1 | Read request ready |
| arAddr | output | ADDR_W | Read address |
| arId | output | ID_W | Read ID |
| arLen | output | 8 | Read length (beats minus one) |
| arSize | output | 3 | Read beat size code |
| arBurst | output | 2 | Read burst code |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data ready |
| rData | input | DATA_W | Read data |
| rId | input | ID_W | Read data ID |
| rResp | input | 2 | Read response code |
| rLast | input | 1 | Last read beat |
| awValid | output | 1 | Write request valid |
| awReady | input | 1 | Write request ready |
| awAddr | output | ADDR_W | Write address |
| awId | output | ID_W | Write ID |
| awLen | output | 8 | Write length |
| awSize | output | 3 | Write beat size code |
| awBurst | output | 2 | Write burst code |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| wData | output | DATA_W | Write data |
| wStrb | output | DATA_W/8 | Write byte strobes |
| wLast | output | 1 | Last write beat |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Write response ready |
| bId | input | ID_W | Write response ID |
| bResp | input | 2 | Write response code |

## Verification
The assertions assume that the subordinate returns read data and the write response only after the matching request has been handshaked. They also assume it never raises `bValid` before the final write beat is taken, because the ordering and ready checks count handshakes from those events. The bench's subordinate model answers in strict channel order: it raises `rValid` only after the read-address handshake and `bValid` only after collecting every write beat. It inserts random ready and valid gaps but never breaks that order. The early, late, bad-ID and error-response cases also stay within this ordering.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDADDR,
    ST_RDDATA,
    ST_WRADDR,
    ST_WRDATA,
    ST_WRRESP,
    ST_DONE
  } rmwState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureJob;  // latch address, clear counters and error
    logic rdBeat;      // a read beat is taken this cycle
    logic wrBeat;      // a write beat is taken this cycle
    logic rspBeat;     // the write response is taken this cycle
  } rmwStrobe_t;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       jobStart,
  input  logic       arReady,
  input  logic       rValid,
  input  logic       rLast,
  input  logic       awReady,
  input  logic       wReady,
  input  logic       wLastBeat,
  input  logic       bValid,
  output logic       arValid,
  output logic       rReady,
  output logic       awValid,
  output logic       wValid,
  output logic       bReady,
  output logic       jobDone,
  output rmwStrobe_t strobe
);

  rmwState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // outputs depend on state only, so no ready-to-valid path exists
  assign arValid = (stateQ == ST_RDADDR);
  assign rReady  = (stateQ == ST_RDDATA);
  assign awValid = (stateQ == ST_WRADDR);
  assign wValid  = (stateQ == ST_WRDATA);
  assign bReady  = (stateQ == ST_WRRESP);
  assign jobDone = (stateQ == ST_DONE);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (jobStart) begin
          strobe.captureJob = 1'b1;
          stateD = ST_RDADDR;
        end
      end
      ST_RDADDR: if (arReady) stateD = ST_RDDATA;
      ST_RDDATA: begin
        if (rValid) begin
          strobe.rdBeat = 1'b1;
          if (rLast) stateD = ST_WRADDR;
        end
      end
      ST_WRADDR: if (awReady) stateD = ST_WRDATA;
      ST_WRDATA: begin
        if (wReady) begin
          strobe.wrBeat = 1'b1;
          if (wLastBeat) stateD = ST_WRRESP;
        end
      end
      ST_WRRESP: begin
        if (bValid) begin
          strobe.rspBeat = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int BEATS  = 16,
  parameter int JOB_ID = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rmwStrobe_t        strobe,
  input  logic [ADDR_W-1:0] jobAddr,
  input  logic [DATA_W-1:0] rData,
  input  logic [ID_W-1:0]   rId,
  input  logic [1:0]        rResp,
  input  logic              rLast,
  input  logic [ID_W-1:0]   bId,
  input  logic [1:0]        bResp,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [DATA_W-1:0] wData,
  output logic              wLastBeat,
  output logic              errSticky
);

  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int CNT_W = $clog2(BEATS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BEATS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BEATS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);
  localparam logic [ID_W-1:0]  OWN_ID   = ID_W'(JOB_ID);
  localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] slotMem [BEATS];
  logic [CNT_W-1:0]  rdCnt;
  logic [IDX_W-1:0]  wrIdx;
  logic              slotFree;
  logic              rdFault;
  logic              rspFault;

  assign slotFree = (rdCnt < FULL_CNT);
  // rLast must coincide with the final slot; a mismatch either way is a fault
  assign rdFault  = (rResp != RESP_OKAY) || (rId != OWN_ID) ||
                    (rLast != (rdCnt == LAST_CNT));
  assign rspFault = (bResp != RESP_OKAY) || (bId != OWN_ID);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr  <= '0;
      rdCnt     <= '0;
      wrIdx     <= '0;
      errSticky <= 1'b0;
    end else begin
      if (strobe.captureJob) begin
        baseAddr  <= jobAddr;
        rdCnt     <= '0;
        wrIdx     <= '0;
        errSticky <= 1'b0;
      end
      if (strobe.rdBeat) begin
        if (slotFree) rdCnt <= rdCnt + 1'b1;
        if (rdFault)  errSticky <= 1'b1;
      end
      if (strobe.wrBeat) wrIdx <= wrIdx + 1'b1;
      if (strobe.rspBeat && rspFault) errSticky <= 1'b1;
    end
  end

  // slot store: no reset, only filled slots are ever meaningful
  always_ff @(posedge clk) begin
    if (strobe.rdBeat && slotFree) slotMem[rdCnt[IDX_W-1:0]] <= rData + ONE;
  end

  assign wData     = slotMem[wrIdx];
  assign wLastBeat = (wrIdx == LAST_IDX);

endmodule

// File: rtl/burst_rmw_mgr.sv
module burst_rmw_mgr
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int BEATS  = 16,
  parameter int JOB_ID = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                jobStart,
  input  logic [ADDR_W-1:0]   jobAddr,
  output logic                jobDone,
  output logic                jobErr,
  output logic                arValid,
  input  logic                arReady,
  output logic [ADDR_W-1:0]   arAddr,
  output logic [ID_W-1:0]     arId,
  output logic [7:0]          arLen,
  output logic [2:0]          arSize,
  output logic [1:0]          arBurst,
  input  logic                rValid,
  output logic                rReady,
  input  logic [DATA_W-1:0]   rData,
  input  logic [ID_W-1:0]     rId,
  input  logic [1:0]          rResp,
  input  logic                rLast,
  output logic                awValid,
  input  logic                awReady,
  output logic [ADDR_W-1:0]   awAddr,
  output logic [ID_W-1:0]     awId,
  output logic [7:0]          awLen,
  output logic [2:0]          awSize,
  output logic [1:0]          awBurst,
  output logic                wValid,
  input  logic                wReady,
  output logic [DATA_W-1:0]   wData,
  output logic [DATA_W/8-1:0] wStrb,
  output logic                wLast,
  input  logic                bValid,
  output logic                bReady,
  input  logic [ID_W-1:0]     bId,
  input  logic [1:0]          bResp
);

  localparam int STRB_W = DATA_W / 8;
  localparam logic [7:0] LEN_CODE  = 8'(BEATS - 1);
  localparam logic [2:0] SIZE_CODE = 3'($clog2(STRB_W));

  rmwStrobe_t        strobe;
  logic [ADDR_W-1:0] baseAddr;
  logic              wLastBeat;

  rmw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .jobStart  (jobStart),
    .arReady   (arReady),
    .rValid    (rValid),
    .rLast     (rLast),
    .awReady   (awReady),
    .wReady    (wReady),
    .wLastBeat (wLastBeat),
    .bValid    (bValid),
    .arValid   (arValid),
    .rReady    (rReady),
    .awValid   (awValid),
    .wValid    (wValid),
    .bReady    (bReady),
    .jobDone   (jobDone),
    .strobe    (strobe)
  );

  rmw_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .BEATS  (BEATS),
    .JOB_ID (JOB_ID)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .jobAddr   (jobAddr),
    .rData     (rData),
    .rId       (rId),
    .rResp     (rResp),
    .rLast     (rLast),
    .bId       (bId),
    .bResp     (bResp),
    .baseAddr  (baseAddr),
    .wData     (wData),
    .wLastBeat (wLastBeat),
    .errSticky (jobErr)
  );

  assign arAddr  = baseAddr;
  assign awAddr  = baseAddr;
  assign arId    = ID_W'(JOB_ID);
  assign awId    = ID_W'(JOB_ID);
  assign arLen   = LEN_CODE;
  assign awLen   = LEN_CODE;
  assign arSize  = SIZE_CODE;
  assign awSize  = SIZE_CODE;
  assign arBurst = BURST_INCR;
  assign awBurst = BURST_INCR;
  assign wStrb   = {STRB_W{1'b1}};
  assign wLast   = wLastBeat;

endmodule

// File: rtl/burst_rmw_mgr_chk.sv
module burst_rmw_mgr_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              arValid,
  input logic              arReady,
  input logic [ADDR_W-1:0] arAddr,
  input logic              rValid,
  input logic              rReady,
  input logic              rLast,
  input logic              awValid,
  input logic              awReady,
  input logic [ADDR_W-1:0] awAddr,
  input logic              wValid,
  input logic              wReady,
  input logic [DATA_W-1:0] wData,
  input logic              wLast,
  input logic              bValid,
  input logic              bReady,
  input logic              jobDone
);

  localparam int CNT_W = $clog2(BEATS + 1);

  logic             readOpen;
  logic             readDone;
  logic             waitResp;
  logic [CNT_W-1:0] wCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readOpen <= 1'b0;
      readDone <= 1'b0;
      waitResp <= 1'b0;
      wCnt     <= '0;
    end else begin
      if (arValid && arReady) begin
        readOpen <= 1'b1;
        readDone <= 1'b0;
      end
      if (rValid && rReady && rLast) begin
        readOpen <= 1'b0;
        readDone <= 1'b1;
      end
      if (awValid && awReady) wCnt <= '0;
      else if (wValid && wReady) wCnt <= wCnt + 1'b1;
      if (wValid && wReady && wLast) waitResp <= 1'b1;
      if (bValid && bReady) waitResp <= 1'b0;
    end
  end

  // R7
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && !arReady) |=> (arValid && $stable(arAddr)));

  // R7
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) |=> (awValid && $stable(awAddr)));

  // R7
  w_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && !wReady) |=> (wValid && $stable(wData) && $stable(wLast)));

  // R3
  rready_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    readOpen |-> rReady);

  // R5
  aw_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> readDone);

  // R6
  wlast_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> (wLast == (wCnt == CNT_W'(BEATS - 1))));

  // R8
  bready_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitResp |-> bReady);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    jobDone |=> !jobDone);

endmodule

bind burst_rmw_mgr burst_rmw_mgr_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BEATS  (BEATS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .arValid (arValid),
  .arReady (arReady),
  .arAddr  (arAddr),
  .rValid  (rValid),
  .rReady  (rReady),
  .rLast   (rLast),
  .awValid (awValid),
  .awReady (awReady),
  .awAddr  (awAddr),
  .wValid  (wValid),
  .wReady  (wReady),
  .wData   (wData),
  .wLast   (wLast),
  .bValid  (bValid),
  .bReady  (bReady),
  .jobDone (jobDone)
);

// File: tb/burst_rmw_mgr_bench.sv
module burst_rmw_mgr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int ID_W   = 4;
  localparam int BEATS  = 16;
  localparam int JOB_ID = 3;
  localparam int WATCHDOG_CYCLES = 150000;

  // stimulus modes
  localparam int M_NORMAL = 0;
  localparam int M_RRESP  = 1;
  localparam int M_EARLY  = 2;
  localparam int M_LATE   = 3;
  localparam int M_BRESP  = 4;
  localparam int M_RID    = 5;
  localparam int M_POKE   = 6;
  localparam int M_WRAP   = 7;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                jobStart = 1'b0;
  logic [ADDR_W-1:0]   jobAddr = '0;
  logic                jobDone, jobErr;
  logic                arValid, arReady = 1'b0;
  logic [ADDR_W-1:0]   arAddr;
  logic [ID_W-1:0]     arId;
  logic [7:0]          arLen;
  logic [2:0]          arSize;
  logic [1:0]          arBurst;
  logic                rValid = 1'b0, rReady;
  logic [DATA_W-1:0]   rData = '0;
  logic [ID_W-1:0]     rId = '0;
  logic [1:0]          rResp = '0;
  logic                rLast = 1'b0;
  logic                awValid, awReady = 1'b0;
  logic [ADDR_W-1:0]   awAddr;
  logic [ID_W-1:0]     awId;
  logic [7:0]          awLen;
  logic [2:0]          awSize;
  logic [1:0]          awBurst;
  logic                wValid, wReady = 1'b0;
  logic [DATA_W-1:0]   wData;
  logic [DATA_W/8-1:0] wStrb;
  logic                wLast;
  logic                bValid = 1'b0, bReady;
  logic [ID_W-1:0]     bId = '0;
  logic [1:0]          bResp = '0;

  int testsRun = 0;
  int testsFailed = 0;
  logic [DATA_W-1:0] srcData [BEATS + 1];
  logic [DATA_W-1:0] expSlot [BEATS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_rmw_mgr #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .ID_W (ID_W),
    .BEATS (BEATS), .JOB_ID (JOB_ID)
  ) u_burst_rmw_mgr (
    .clk (clk), .rstN (rstN), .jobStart (jobStart), .jobAddr (jobAddr),
    .jobDone (jobDone), .jobErr (jobErr),
    .arValid (arValid), .arReady (arReady), .arAddr (arAddr), .arId (arId),
    .arLen (arLen), .arSize (arSize), .arBurst (arBurst),
    .rValid (rValid), .rReady (rReady), .rData (rData), .rId (rId),
    .rResp (rResp), .rLast (rLast),
    .awValid (awValid), .awReady (awReady), .awAddr (awAddr), .awId (awId),
    .awLen (awLen), .awSize (awSize), .awBurst (awBurst),
    .wValid (wValid), .wReady (wReady), .wData (wData), .wStrb (wStrb),
    .wLast (wLast),
    .bValid (bValid), .bReady (bReady), .bId (bId), .bResp (bResp)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] bumped(input logic [DATA_W-1:0] v);
    return v + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic bit modeErrs(input int mode);
    return (mode == M_RRESP) || (mode == M_EARLY) || (mode == M_LATE) ||
           (mode == M_BRESP) || (mode == M_RID);
  endfunction

  task automatic stall(input int maxCycles);
    int n = $urandom % (maxCycles + 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic runJob(input logic [ADDR_W-1:0] addr, input int mode);
    int nBeats;
    int got;
    int guard;
    bit awEarly;
    bit rGap;
    bit lastOk;
    bit dataOk;
    logic [DATA_W-1:0] badAct;
    logic [DATA_W-1:0] badExp;
    logic [63:0] reqWord;

    nBeats = (mode == M_EARLY) ? BEATS - 1 : (mode == M_LATE) ? BEATS + 1 : BEATS;
    for (int i = 0; i < BEATS + 1; i++)
      srcData[i] = (mode == M_WRAP) ? {DATA_W{1'b1}} : DATA_W'($urandom);

    @(negedge clk);
    jobAddr  = addr;
    jobStart = 1'b1;
    @(negedge clk);
    jobStart = 1'b0;

    // read request
    guard = 0;
    while (!arValid && guard < 50) begin @(negedge clk); guard++; end
    stall(3);
    reqWord = {arAddr, arId, arLen, arSize, arBurst, 10'd0};
    check(arValid && arAddr == addr && arLen == 8'(BEATS - 1) && arSize == 3'd2 &&
          arBurst == 2'b01 && arId == ID_W'(JOB_ID),
          "R2 read request fields", reqWord,
          {addr, ID_W'(JOB_ID), 8'(BEATS - 1), 3'd2, 2'b01, 10'd0});
    arReady = 1'b1;
    @(negedge clk);
    arReady = 1'b0;

    // read data
    awEarly = 1'b0;
    rGap = 1'b0;
    for (int i = 0; i < nBeats; i++) begin
      int gap = $urandom % 3;
      for (int g = 0; g < gap; g++) begin
        if (awValid) awEarly = 1'b1;
        if (!rReady) rGap = 1'b1;
        @(negedge clk);
      end
      if (mode == M_POKE && i == 3) begin
        jobStart = 1'b1;
        jobAddr  = ~addr;
      end
      rValid = 1'b1;
      rData  = srcData[i];
      rLast  = (i == nBeats - 1);
      rResp  = (mode == M_RRESP && i == 5) ? 2'b10 : 2'b00;
      rId    = (mode == M_RID && i == 2) ? ID_W'(JOB_ID + 1) : ID_W'(JOB_ID);
      if (awValid) awEarly = 1'b1;
      if (!rReady) rGap = 1'b1;
      guard = 0;
      while (!rReady && guard < 50) begin @(negedge clk); guard++; end
      @(negedge clk);
      if (i < BEATS) expSlot[i] = bumped(srcData[i]);
      jobStart = 1'b0;
      rValid = 1'b0;
      rLast  = 1'b0;
      rResp  = 2'b00;
    end
    check(!awEarly, "R5 write request held back until read completes",
          64'(awEarly), 64'd0);
    check(!rGap, "R3 rReady high through read burst", 64'(rGap), 64'd0);

    // write request
    guard = 0;
    while (!awValid && guard < 50) begin @(negedge clk); guard++; end
    stall(3);
    reqWord = {awAddr, awId, awLen, awSize, awBurst, 10'd0};
    check(awValid && awAddr == addr && awLen == 8'(BEATS - 1) && awSize == 3'd2 &&
          awBurst == 2'b01 && awId == ID_W'(JOB_ID),
          "R5 R11 write request fields", reqWord,
          {addr, ID_W'(JOB_ID), 8'(BEATS - 1), 3'd2, 2'b01, 10'd0});
    awReady = 1'b1;
    @(negedge clk);
    awReady = 1'b0;

    // write data
    got = 0;
    guard = 0;
    lastOk = 1'b1;
    dataOk = 1'b1;
    badAct = '0;
    badExp = '0;
    while (got < BEATS && guard < 400) begin
      wReady = ($urandom % 4) != 0;
      if (wValid && wReady) begin
        if (wData !== expSlot[got] && dataOk) begin
          dataOk = 1'b0;
          badAct = wData;
          badExp = expSlot[got];
        end
        if (wLast != (got == BEATS - 1) || wStrb != '1) lastOk = 1'b0;
        got++;
      end
      @(negedge clk);
      guard++;
    end
    wReady = 1'b0;
    check(dataOk, (mode == M_WRAP) ? "R4 wrap to zero" :
                  (mode == M_EARLY || mode == M_LATE) ? "R10 stored slots" :
                  "R4 incremented write-back", 64'(badAct), 64'(badExp));
    check(got == BEATS && lastOk, "R6 beat count, strobes and wLast",
          64'(got), 64'(BEATS));
    check(!wValid, "R6 no extra write beat", 64'(wValid), 64'd0);

    // write response
    stall(3);
    bValid = 1'b1;
    bResp  = (mode == M_BRESP) ? 2'b10 : 2'b00;
    bId    = ID_W'(JOB_ID);
    check(bReady, "R8 bReady while waiting", 64'(bReady), 64'd1);
    guard = 0;
    while (!bReady && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    bValid = 1'b0;
    bResp  = 2'b00;
    check(jobDone === 1'b1, "R8 done after response", 64'(jobDone), 64'd1);
    check(jobErr === modeErrs(mode),
          (mode == M_EARLY || mode == M_LATE) ? "R10 error on misplaced rLast" :
          "R9 error flag with done", 64'(jobErr), 64'(modeErrs(mode)));
    @(negedge clk);
    check(jobDone === 1'b0, "R8 done is one cycle", 64'(jobDone), 64'd0);
    if (mode == M_POKE) begin
      bit seen = 1'b0;
      repeat (4) begin
        if (arValid) seen = 1'b1;
        @(negedge clk);
      end
      check(!seen, "R11 start during job ignored", 64'(seen), 64'd0);
    end
  endtask

  task automatic runAll();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!arValid && !rReady && !awValid && !wValid && !bReady,
          "R1 handshake outputs low in reset",
          64'({arValid, rReady, awValid, wValid, bReady}), 64'd0);
    check(!jobDone && !jobErr, "R1 done and error low in reset",
          64'({jobDone, jobErr}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!arValid && !jobDone && !jobErr, "R1 idle after reset",
          64'({arValid, jobDone, jobErr}), 64'd0);

    for (int j = 0; j < 12; j++)
      runJob(ADDR_W'($urandom) & ~ADDR_W'(3), M_NORMAL);
    runJob(32'h0000_1000, M_WRAP);
    runJob(32'h0000_2000, M_RRESP);
    runJob(32'h0000_3000, M_NORMAL);   // R9 error cleared by new start
    runJob(32'h0000_4000, M_EARLY);
    runJob(32'h0000_5000, M_LATE);
    runJob(32'h0000_6000, M_BRESP);
    runJob(32'h0000_7000, M_RID);
    runJob(32'h0000_8000, M_POKE);
    for (int j = 0; j < 6; j++)
      runJob(ADDR_W'($urandom) & ~ADDR_W'(3), M_NORMAL);
  endtask

  initial begin
    void'($urandom(32'd24681));
    fork
      runAll();
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog actual=expired expected=finished");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule